// File: doc/BRIEF.md
# Dual-Mode Serial Result Shifter

This block sends a latched 16-bit converter result out on a single serial data line, most significant bit first. The word arrives from the conversion logic with a one-cycle strobe and is held until the next strobe. A transfer always loads whatever word is held at that moment, so a read started while a conversion is still running returns the previous result. A read started after the strobe returns the new one. The output coding is chosen at the start of each transfer: plain offset binary, or two's complement, where only the top bit is flipped.

Two clocking modes share one shift register. In self-clocked mode, a convert command (a falling edge of the OR of chip-select-bar and read/convert) makes the block produce exactly 16 data-clock pulses from a divider of the system clock. Each bit changes on a falling edge of the data clock, and the data clock rests low between transfers. Between transfers the data line shows the tag level captured at the command. In host-clocked mode, the external data clock is seen as a one-cycle enable (`xtick`). A read start is either chip-select falling while read/convert is high, or read/convert rising while chip-select is low. The first enable after a read start raises a sync marker for one enable period. Every later enable shifts one bit. The tag input feeds the back of the shift register, so after the 16 result bits the line carries the tag delayed by 16 shifts, which lets several devices be chained.

Top module: `serial_result_shifter`

## Requirements
- R1: After reset, `sdata`, `dclk_out` and `sync_out` are all 0.
- R2: The word sent is `res_word` unchanged when `fmt_straight` is 1. When it is 0, the word has bit 15 inverted (0x8000 goes out as 0x0000, 0x0000 as 0x8000). The coding is fixed by the `fmt_straight` level at the transfer start, and later changes do not affect that transfer.
- R3: In self-clocked mode (`mode_ext`=0), a convert command at clock edge E0 produces exactly 16 `dclk_out` pulses. The pulse has period 2*DCLK_HALF cycles and its first rise is at edge E0+DCLK_HALF. Outside those pulses `dclk_out` is 0.
- R4: In self-clocked mode, bit 15-k is on `sdata` from edge E0+2k*DCLK_HALF until edge E0+2(k+1)*DCLK_HALF, so it changes only on falling data-clock edges and is stable while `dclk_out` is high.
- R5: In self-clocked mode, between transfers `sdata` equals the `tag_in` level sampled at the accepted convert command, whatever `tag_in` does afterwards.
- R6: In self-clocked mode, a convert command that arrives while a transfer is in progress is ignored. The pulse train, the data, the coding and the captured tag all continue unchanged.
- R7: In host-clocked mode, a read start arms the sync marker. The next `xtick` raises `sync_out`, and the `xtick` after that lowers it. `dclk_out` stays 0.
- R8: In host-clocked mode, bit 15 is on `sdata` from the read start. Each `xtick` after the sync one shifts by one bit. After s shifts with s of 16 or more, `sdata` equals the `tag_in` value present at shift s-15.
- R9: In host-clocked mode, when read select (`cs_n`=0 and `rdconv`=1) goes false, shifting stops and `sdata` holds its level through further `xtick` pulses.
- R10: `res_valid` loads `res_word` into the held result. A transfer started before the strobe sends the older word, and a strobe during a transfer does not change the bits of that transfer.
- R11: In host-clocked mode, a convert command (OR of `cs_n` and `rdconv` falling without read select) starts no transfer and no sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ext | input | 1 | 1 = host-clocked mode, 0 = self-clocked mode |
| fmt_straight | input | 1 | 1 = offset binary, 0 = two's complement |
| cs_n | input | 1 | Chip select, active low |
| rdconv | input | 1 | Read/convert control: low = convert, high = read |
| res_valid | input | 1 | One-cycle strobe that a new result is on res_word |
| res_word | input | WIDTH | Conversion result, offset binary |
| tag_in | input | 1 | Tag level for idle data and for chaining |
| xtick | input | 1 | One-cycle enable per external data-clock pulse |
| sdata | output | 1 | Serial data, MSB first |
| dclk_out | output | 1 | Generated data clock in self-clocked mode |
| sync_out | output | 1 | Frame marker in host-clocked mode |

## Verification
A wrong bit counter or divider shows up at the ports within one data-clock half period. It appears as a seventeenth pulse, a missing pulse, or a bit that changes while the data clock is high, and every cycle of each self-clocked transfer is compared. A corrupt held result or coding choice shows in the first bit that differs, so words with the top bit, the low bit and alternating patterns set are sent in both codings and both modes. A broken tag path or sync arming appears 16 shifts after the start, or on the first enable after it. Each host-clocked read therefore runs twenty shifts past the result, with a tag pattern that changes on every shift.

// File: rtl/serial_result_shifter.sv
module serial_result_shifter #(
  parameter int WIDTH     = 16,
  parameter int DCLK_HALF = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ext,
  input  logic             fmt_straight,
  input  logic             cs_n,
  input  logic             rdconv,
  input  logic             res_valid,
  input  logic [WIDTH-1:0] res_word,
  input  logic             tag_in,
  input  logic             xtick,
  output logic             sdata,
  output logic             dclk_out,
  output logic             sync_out
);

  localparam int DIVW = (DCLK_HALF > 1) ? $clog2(DCLK_HALF) : 1;
  localparam int BCW  = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] SIGN_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] held, sh;
  logic [DIVW-1:0]  div;
  logic [BCW-1:0]   bitn;
  logic cmb_q, rsel_q, busy, dclk_q, tag_hold;
  logic sync_q, sync_wait, ext_run;

  logic cmb, rsel, conv_cmd, rd_start, int_go, ext_go, half_end, ext_shift, int_shift;
  logic [WIDTH-1:0] coded;

  assign cmb       = cs_n | rdconv;
  assign rsel      = ~cs_n & rdconv;
  assign conv_cmd  = cmb_q & ~cmb;
  assign rd_start  = rsel & ~rsel_q;
  assign coded     = fmt_straight ? held : (held ^ SIGN_BIT);
  assign int_go    = conv_cmd & ~mode_ext & ~busy;
  assign ext_go    = rd_start & mode_ext;
  assign half_end  = (div == DIVW'(DCLK_HALF - 1));
  assign int_shift = busy & half_end & dclk_q;
  assign ext_shift = mode_ext & ext_run & rsel & xtick & ~sync_wait;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= '0;
      cmb_q  <= 1'b0;
      rsel_q <= 1'b1;
    end else begin
      if (res_valid) held <= res_word;
      cmb_q  <= cmb;
      rsel_q <= rsel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      div      <= '0;
      bitn     <= '0;
      dclk_q   <= 1'b0;
      tag_hold <= 1'b0;
    end else if (int_go) begin
      busy     <= 1'b1;
      div      <= '0;
      bitn     <= '0;
      dclk_q   <= 1'b0;
      tag_hold <= tag_in;
    end else if (busy) begin
      if (half_end) begin
        div    <= '0;
        dclk_q <= ~dclk_q;
        if (dclk_q) begin
          if (bitn == BCW'(WIDTH - 1)) busy <= 1'b0;
          else                         bitn <= bitn + 1'b1;
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_run   <= 1'b0;
      sync_wait <= 1'b0;
      sync_q    <= 1'b0;
    end else if (ext_go) begin
      ext_run   <= 1'b1;
      sync_wait <= 1'b1;
      sync_q    <= 1'b0;
    end else begin
      if (ext_run && (!rsel || !mode_ext)) begin
        ext_run   <= 1'b0;
        sync_wait <= 1'b0;
      end else if (ext_run && xtick && sync_wait) begin
        sync_wait <= 1'b0;
      end
      if (xtick && sync_q)
        sync_q <= 1'b0;
      else if (xtick && sync_wait && ext_run && rsel && mode_ext)
        sync_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 sh <= '0;
    else if (int_go || ext_go)  sh <= coded;
    else if (ext_shift)         sh <= {sh[WIDTH-2:0], tag_in};
    else if (int_shift)         sh <= {sh[WIDTH-2:0], 1'b0};
  end

  assign sdata    = (mode_ext || busy) ? sh[WIDTH-1] : tag_hold;
  assign dclk_out = dclk_q;
  assign sync_out = sync_q;

endmodule

module serial_result_shifter_chk #(
  parameter int WIDTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic mode_ext,
  input logic cs_n,
  input logic rdconv,
  input logic xtick,
  input logic sdata,
  input logic dclk_out,
  input logic sync_out
);

  localparam int PCW = $clog2(WIDTH + 2);

  logic cmb_c, rsel_c, dclk_d;
  logic [PCW-1:0] pcnt;
  logic cmb_now, rsel_now;

  assign cmb_now  = cs_n | rdconv;
  assign rsel_now = ~cs_n & rdconv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmb_c  <= 1'b0;
      rsel_c <= 1'b1;
      dclk_d <= 1'b0;
      pcnt   <= '0;
    end else begin
      cmb_c  <= cmb_now;
      rsel_c <= rsel_now;
      dclk_d <= dclk_out;
      if (cmb_c && !cmb_now && !mode_ext)
        pcnt <= '0;
      else if (dclk_out && !dclk_d && (int'(pcnt) <= WIDTH))
        pcnt <= pcnt + 1'b1;
    end
  end

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pcnt) <= WIDTH); // R3

  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ext && dclk_out && $past(dclk_out)) |-> $stable(sdata)); // R4

  AST_EXT_NO_DCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ext && !dclk_out) |=> (!mode_ext || !dclk_out)); // R7

  AST_SYNC_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> ($past(xtick) && $past(mode_ext))); // R7

  AST_SYNC_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_out) |-> $past(xtick)); // R7

  AST_EXT_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ext && $past(mode_ext) && !$stable(sdata))
      |-> ($past(xtick) || $past(rsel_now && !rsel_c))); // R8

endmodule

bind serial_result_shifter serial_result_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .cs_n(cs_n), .rdconv(rdconv),
  .xtick(xtick), .sdata(sdata), .dclk_out(dclk_out), .sync_out(sync_out)
);

// File: tb/tb_serial_result_shifter.sv
module tb_serial_result_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n, mode_ext, fmt_straight, cs_n, rdconv, res_valid, tag_in, xtick;
  logic [W-1:0] res_word;
  logic sdata, dclk_out, sync_out;

  int total = 0;
  int bad = 0;
  logic [W-1:0] cur_word;
  logic last_ext;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_result_shifter #(.WIDTH(W), .DCLK_HALF(H)) dut (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .fmt_straight(fmt_straight),
    .cs_n(cs_n), .rdconv(rdconv), .res_valid(res_valid), .res_word(res_word),
    .tag_in(tag_in), .xtick(xtick), .sdata(sdata), .dclk_out(dclk_out),
    .sync_out(sync_out)
  );

  task automatic chk(input logic ok, input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] word_of(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h7FFF;
      4: return 16'h0001;
      5: return 16'hA5C3;
      6: return 16'h1234;
      default: return 16'hFFFE;
    endcase
  endfunction

  function automatic logic tagpat(input int j);
    return ((j * 5 + 3) % 7) > 3;
  endfunction

  function automatic logic [W-1:0] encode(input logic [W-1:0] w, input logic f);
    return f ? w : (w ^ 16'h8000);
  endfunction

  task automatic load_word(input logic [W-1:0] w);
    @(negedge clk);
    res_word = w; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    cur_word = w;
  endtask

  // self-clocked transfer, checked every cycle
  task automatic int_read(input logic t, input bit glitch);
    logic [W-1:0] code;
    logic f0;
    logic exp_d, exp_c;
    code = encode(cur_word, fmt_straight);
    f0 = fmt_straight;
    @(negedge clk);
    rdconv = 1'b0; tag_in = t;
    for (int c = 0; c < 32*H + 4; c++) begin
      @(posedge clk);
      @(negedge clk);
      exp_c = (c < 32*H) && (((c / H) % 2) == 1);
      exp_d = (c < 32*H) ? code[W-1 - c/(2*H)] : t;
      chk(dclk_out == exp_c, glitch ? "R6 R3 dclk" : "R3 dclk", {15'd0, dclk_out}, {15'd0, exp_c});
      chk(sdata == exp_d, (c < 32*H) ? (glitch ? "R6 R2 R4 data" : "R2 R4 data") : "R5 idle tag",
          {15'd0, sdata}, {15'd0, exp_d});
      if (c == 0) tag_in = ~t;
      if (glitch && c == 4) begin rdconv = 1'b1; fmt_straight = ~f0; end
      if (glitch && c == 6) begin rdconv = 1'b0; tag_in = t; end
      if (glitch && c == 8) begin res_word = ~cur_word; res_valid = 1'b1; end
      if (glitch && c == 9) begin res_valid = 1'b0; cur_word = res_word; end
    end
    rdconv = 1'b1;
    fmt_straight = f0;
  endtask

  task automatic tick(input logic tg);
    @(negedge clk);
    xtick = 1'b1; tag_in = tg;
    @(posedge clk);
    @(negedge clk);
    xtick = 1'b0;
  endtask

  // host-clocked transfer; form 1 starts by read/convert rising after a convert command
  task automatic ext_read(input bit form, input bit new_mid);
    logic [W-1:0] code;
    logic exp_d;
    int s;
    code = encode(cur_word, fmt_straight);
    if (form) begin
      @(negedge clk); rdconv = 1'b0;
      @(negedge clk); cs_n = 1'b0;
      for (int k = 0; k < 2; k++) begin
        tick(1'b1);
        chk(sync_out == 1'b0, "R11 no sync", {15'd0, sync_out}, 16'd0);
        chk(sdata == last_ext, "R11 data kept", {15'd0, sdata}, {15'd0, last_ext});
      end
      @(negedge clk); rdconv = 1'b1;
    end else begin
      @(negedge clk); cs_n = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(sdata == code[W-1], "R8 msb at start", {15'd0, sdata}, {15'd0, code[W-1]});
    chk(sync_out == 1'b0, "R7 sync armed low", {15'd0, sync_out}, 16'd0);
    chk(dclk_out == 1'b0, "R7 no dclk", {15'd0, dclk_out}, 16'd0);
    for (int i = 1; i <= W + 21; i++) begin
      tick(tagpat(i));
      s = i - 1;
      exp_d = (s < W) ? code[W-1-s] : tagpat(s - 14);
      chk(sync_out == (i == 1), "R7 sync", {15'd0, sync_out}, {15'd0, (i == 1)});
      chk(sdata == exp_d, (s < W) ? "R2 R8 bit" : "R8 tag delay", {15'd0, sdata}, {15'd0, exp_d});
      if (new_mid && i == 5) begin res_word = ~cur_word; res_valid = 1'b1; end
      @(posedge clk);
      @(negedge clk);
      if (new_mid && i == 5) begin res_valid = 1'b0; cur_word = res_word; end
      chk(sdata == exp_d, new_mid ? "R10 R8 hold between ticks" : "R8 hold between ticks",
          {15'd0, sdata}, {15'd0, exp_d});
      chk(sync_out == (i == 1), "R7 sync width", {15'd0, sync_out}, {15'd0, (i == 1)});
      last_ext = exp_d;
    end
    @(negedge clk); cs_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick(~last_ext);
      chk(sdata == last_ext, "R9 frozen", {15'd0, sdata}, {15'd0, last_ext});
      chk(sync_out == 1'b0, "R9 no sync", {15'd0, sync_out}, 16'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_ext = 1'b0; fmt_straight = 1'b1; cs_n = 1'b1; rdconv = 1'b1;
    res_valid = 1'b0; res_word = '0; tag_in = 1'b0; xtick = 1'b0;
    cur_word = '0; last_ext = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sdata == 1'b0, "R1 sdata", {15'd0, sdata}, 16'd0);
    chk(dclk_out == 1'b0, "R1 dclk", {15'd0, dclk_out}, 16'd0);
    chk(sync_out == 1'b0, "R1 sync", {15'd0, sync_out}, 16'd0);

    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      for (int f = 0; f < 2; f++) begin
        fmt_straight = f[0];
        load_word(word_of(i));
        int_read(logic'((i + f) % 2), 1'b0);
        repeat (3) begin
          @(negedge clk);
          chk(dclk_out == 1'b0, "R3 idle low", {15'd0, dclk_out}, 16'd0);
        end
      end
    end
    // ignored command, late format flip and mid-transfer strobe
    load_word(16'h3C96);
    fmt_straight = 1'b0;
    int_read(1'b1, 1'b1);
    fmt_straight = 1'b1;
    int_read(1'b0, 1'b0);

    @(negedge clk);
    cs_n = 1'b1; rdconv = 1'b1; mode_ext = 1'b1;
    last_ext = 1'b0;
    for (int i = 0; i < 4; i++) begin
      for (int f = 0; f < 2; f++) begin
        fmt_straight = f[0];
        load_word(word_of(i * 2 + f));
        ext_read(f[0], 1'b0);
      end
    end
    fmt_straight = 1'b0;
    load_word(16'h5A0F);
    ext_read(1'b0, 1'b1);
    ext_read(1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule